// File: doc/BRIEF.md
# Multi-Line DMA Transmit Scheduler

This block feeds up to sixteen outbound byte streams from memory. Each line has its own 18-bit current address and 16-bit byte count. The host reaches one line's address and count at a time. It does this by writing a line number into the control register. It then loads the start address and the negated length, and starts the line by setting that line's bit in the active mask. The scheduler walks the active lines in round-robin order and keeps one memory read outstanding at a time. It delivers each returned byte into a one-byte holding buffer on that line's output. The downstream serialiser takes the byte with a valid/ready handshake.

The count is written as minus the number of bytes and rises by one for every byte fetched. The address rises by one for every byte fetched. When a line's count reaches zero and no read is in flight for it, the hardware clears its active bit and raises the transmit flag. The flag drives the interrupt output when its enable is set. To stop a running line early, the host writes a count of all ones. It can then read the address to learn how far the transfer got. A read that returns an error marks the nonexistent-memory condition and retires the line at once.

Top module: `dma_tx_sched`

## Requirements
- R1: After reset the control register and active mask read 0, and `irq`, `mem_req` and every `out_valid` bit are low.
- R2: The register select values are 0 = control, 1 = address, 2 = count and 3 = active mask. Control bits 3:0 pick the line. Writes to registers 1 and 2 land in that line only, and reads of registers 1 and 2 return that line's values.
- R3: A write to the address register stores control bits 5:4 as address bits 17:16 above the 16 written bits. The full 18-bit address is presented on `mem_addr`. Reading control bits 5:4 returns bits 17:16 of the selected line's current address.
- R4: Writing a 1 to a bit of the active mask starts that line, and writing a 0 has no effect. A started line with count -n delivers exactly n bytes on its output, in order, from address a, a+1, … a+n-1.
- R5: Each good byte returned from memory adds one to the line's address and one to its count. At the end of a transfer the address is the start plus n and the count is 0; an 18-bit carry passes from bit 15 into bit 16.
- R6: When an active line's count is zero and it has no read in flight, its active bit clears and control bit 15 (transmit flag) sets. `irq` equals bit 15 AND bit 13 (enable). A control write with bit 15 = 0 clears the flag, and a write with bit 15 = 1 leaves it unchanged.
- R7: Writing count 0xFFFF (-1) to a running line ends it after at most one more fetched byte. This is in addition to any byte already waiting in its holding buffer.
- R8: At most one memory read is outstanding. Grants rotate to the next requesting line after the last one granted. A line whose holding byte has not been taken is not fetched for.
- R9: An error response sets control bit 10. It also clears the line's active bit and sets the transmit flag, and leaves the address and count unchanged. A control write with bit 8 = 1 clears bit 10.
- R10: Starting a line whose count is 0 retires it with no memory read and sets the transmit flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 2 | Register select |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Read data for the selected register |
| irq | output | 1 | Transmit interrupt |
| mem_req | output | 1 | One-cycle memory read request |
| mem_addr | output | 18 | Memory read byte address |
| mem_rvalid | input | 1 | Memory response valid |
| mem_rdata | input | 8 | Memory response byte |
| mem_err | input | 1 | Response refers to nonexistent memory |
| out_valid | output | NLINES | Holding byte valid, one per line |
| out_data | output | NLINES*8 | Holding bytes, line i at bits 8i+7:8i |
| out_ready | input | NLINES | Downstream takes the byte, one per line |

## Verification
Several patterns exercise the main function. A single line whose address crosses the 64 KiB boundary shows the address carry and the extension bits. Three lines of different lengths started in one mask write show the round-robin order, because the predicted delivery order differs from first-come order. A line held back by its serialiser and then cut short separates the backpressure stall from the early-stop limit. An error-returning address and a zero-length start show the two ways a line retires without delivering data.

// File: rtl/dma_tx_pkg.sv
package dma_tx_pkg;
  localparam int HW = 16;

  typedef enum logic [1:0] {
    RG_CTRL = 2'd0,
    RG_ADDR = 2'd1,
    RG_CNT  = 2'd2,
    RG_MASK = 2'd3
  } reg_sel_e;

  localparam int CB_EXT   = 4;
  localparam int CB_NXCLR = 8;
  localparam int CB_NXM   = 10;
  localparam int CB_TIE   = 13;
  localparam int CB_TI    = 15;
endpackage

// File: rtl/dma_rr_arb.sv
module dma_rr_arb #(
  parameter int N  = 16,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  input  logic          advance,
  output logic          grant_any,
  output logic [IW-1:0] grant_idx
);
  logic [IW-1:0] ptr_q;

  always_comb begin
    grant_any = 1'b0;
    grant_idx = '0;
    for (int k = 0; k < N; k++) begin
      int pos;
      pos = (int'(ptr_q) + k) % N;
      if (!grant_any && req[pos]) begin
        grant_any = 1'b1;
        grant_idx = IW'(pos);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else if (advance) ptr_q <= (int'(grant_idx) == N - 1) ? '0 : grant_idx + 1'b1;
  end
endmodule

// File: rtl/dma_line_buf.sv
module dma_line_buf #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] ldata,
  input  logic          ready,
  output logic          valid,
  output logic [DW-1:0] data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      data  <= '0;
    end else if (load) begin
      valid <= 1'b1;
      data  <= ldata;
    end else if (ready) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/dma_tx_sched.sv
module dma_tx_sched
  import dma_tx_pkg::*;
#(
  parameter int NLINES = 16,
  parameter int AHI    = 2,
  parameter int CW     = 16,
  parameter int DW     = 8,
  localparam int SELW  = $clog2(NLINES),
  localparam int ALO   = HW,
  localparam int AW    = ALO + AHI
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 host_we,
  input  logic [1:0]           host_addr,
  input  logic [HW-1:0]        host_wdata,
  output logic [HW-1:0]        host_rdata,
  output logic                 irq,
  output logic                 mem_req,
  output logic [AW-1:0]        mem_addr,
  input  logic                 mem_rvalid,
  input  logic [DW-1:0]        mem_rdata,
  input  logic                 mem_err,
  output logic [NLINES-1:0]    out_valid,
  output logic [NLINES*DW-1:0] out_data,
  input  logic [NLINES-1:0]    out_ready
);
  function automatic logic [CW-1:0] cnt_step(input logic [CW-1:0] c);
    return c + 1'b1;
  endfunction

  function automatic logic [AW-1:0] addr_step(input logic [AW-1:0] a);
    return a + 1'b1;
  endfunction

  logic [AW-1:0]     addr_q [NLINES];
  logic [CW-1:0]     cnt_q  [NLINES];
  logic [SELW-1:0]   sel_q;
  logic [AHI-1:0]    ext_q;
  logic              tie_q, ti_q, nxm_q;
  logic [NLINES-1:0] active_q;
  logic              busy_q;
  logic [SELW-1:0]   infl_q;

  // decoded host events
  logic wr_ctrl, wr_addr, wr_cnt, wr_mask;
  assign wr_ctrl = host_we && (reg_sel_e'(host_addr) == RG_CTRL);
  assign wr_addr = host_we && (reg_sel_e'(host_addr) == RG_ADDR);
  assign wr_cnt  = host_we && (reg_sel_e'(host_addr) == RG_CNT);
  assign wr_mask = host_we && (reg_sel_e'(host_addr) == RG_MASK);

  // named internal events
  logic [NLINES-1:0] cnt_zero, inflight_vec, req_vec, retire_vec, err_vec, load_vec;
  logic              grant_any, advance, resp_ok, resp_err;
  logic [SELW-1:0]   grant_idx;

  assign resp_ok  = mem_rvalid && busy_q && !mem_err;
  assign resp_err = mem_rvalid && busy_q && mem_err;

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    logic [DW-1:0] bdata;
    assign cnt_zero[g]     = (cnt_q[g] == '0);
    assign inflight_vec[g] = busy_q && (infl_q == SELW'(g));
    assign load_vec[g]     = resp_ok && (infl_q == SELW'(g));
    assign err_vec[g]      = resp_err && (infl_q == SELW'(g));
    assign req_vec[g]      = active_q[g] && !cnt_zero[g] && !out_valid[g] && !inflight_vec[g];
    assign retire_vec[g]   = active_q[g] && cnt_zero[g] && !inflight_vec[g];

    dma_line_buf #(.DW(DW)) u_buf (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (load_vec[g]),
      .ldata (mem_rdata),
      .ready (out_ready[g]),
      .valid (out_valid[g]),
      .data  (bdata)
    );
    assign out_data[g*DW +: DW] = bdata;
  end

  dma_rr_arb #(.N(NLINES)) u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (req_vec),
    .advance   (advance),
    .grant_any (grant_any),
    .grant_idx (grant_idx)
  );

  assign advance  = grant_any && !busy_q;
  assign mem_req  = advance;
  assign mem_addr = addr_q[grant_idx];

  // per-line address and count
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NLINES; i++) begin
        addr_q[i] <= '0;
        cnt_q[i]  <= '0;
      end
    end else begin
      for (int i = 0; i < NLINES; i++) begin
        logic host_hit_a, host_hit_c;
        logic [CW-1:0] cbase;
        host_hit_a = wr_addr && (sel_q == SELW'(i));
        host_hit_c = wr_cnt && (sel_q == SELW'(i));
        cbase      = host_hit_c ? host_wdata[CW-1:0] : cnt_q[i];
        if (host_hit_a)       addr_q[i] <= {ext_q, host_wdata[ALO-1:0]};
        else if (load_vec[i]) addr_q[i] <= addr_step(addr_q[i]);
        if (load_vec[i])      cnt_q[i]  <= cnt_step(cbase);
        else if (host_hit_c)  cnt_q[i]  <= cbase;
      end
    end
  end

  // control, mask and fetch tracking
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q    <= '0;
      ext_q    <= '0;
      tie_q    <= 1'b0;
      ti_q     <= 1'b0;
      nxm_q    <= 1'b0;
      active_q <= '0;
      busy_q   <= 1'b0;
      infl_q   <= '0;
    end else begin
      if (wr_ctrl) begin
        sel_q <= host_wdata[SELW-1:0];
        ext_q <= host_wdata[CB_EXT +: AHI];
        tie_q <= host_wdata[CB_TIE];
      end
      ti_q  <= (ti_q && !(wr_ctrl && !host_wdata[CB_TI])) || (|retire_vec) || resp_err;
      nxm_q <= (nxm_q && !(wr_ctrl && host_wdata[CB_NXCLR])) || resp_err;
      active_q <= (active_q & ~retire_vec & ~err_vec)
                | (wr_mask ? host_wdata[NLINES-1:0] : '0);
      if (advance) begin
        busy_q <= 1'b1;
        infl_q <= grant_idx;
      end else if (mem_rvalid) begin
        busy_q <= 1'b0;
      end
    end
  end

  assign irq = ti_q && tie_q;

  always_comb begin
    host_rdata = '0;
    case (reg_sel_e'(host_addr))
      RG_CTRL: begin
        host_rdata[SELW-1:0]     = sel_q;
        host_rdata[CB_EXT +: AHI] = addr_q[sel_q][AW-1:ALO];
        host_rdata[CB_NXM]       = nxm_q;
        host_rdata[CB_TIE]       = tie_q;
        host_rdata[CB_TI]        = ti_q;
      end
      RG_ADDR: host_rdata = addr_q[sel_q][ALO-1:0];
      RG_CNT:  host_rdata[CW-1:0] = cnt_q[sel_q];
      default: host_rdata[NLINES-1:0] = active_q;
    endcase
  end
endmodule

// File: rtl/dma_tx_sched_chk.sv
module dma_tx_sched_chk
  import dma_tx_pkg::*;
#(
  parameter int NLINES = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_req,
  input logic              mem_rvalid,
  input logic              mem_err,
  input logic              busy_q,
  input logic [NLINES-1:0] load_vec,
  input logic [NLINES-1:0] retire_vec,
  input logic [NLINES-1:0] active_q,
  input logic              ti_q,
  input logic              nxm_q,
  input logic              host_we,
  input logic [1:0]        host_addr
);
  a_r8_single_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !busy_q);

  a_r8_req_gap: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);

  a_r8_one_load: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(load_vec));

  a_r6_retire_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (|retire_vec) |=> ti_q);

  a_r6_retire_clears_bit: assert property (@(posedge clk) disable iff (!rst_n)
    ((|retire_vec) && !(host_we && host_addr == RG_MASK))
      |=> ((active_q & $past(retire_vec)) == '0));

  a_r9_err_sets_nxm: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rvalid && busy_q && mem_err) |=> (nxm_q && ti_q));
endmodule

bind dma_tx_sched dma_tx_sched_chk #(.NLINES(NLINES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mem_req    (mem_req),
  .mem_rvalid (mem_rvalid),
  .mem_err    (mem_err),
  .busy_q     (busy_q),
  .load_vec   (load_vec),
  .retire_vec (retire_vec),
  .active_q   (active_q),
  .ti_q       (ti_q),
  .nxm_q      (nxm_q),
  .host_we    (host_we),
  .host_addr  (host_addr)
);

// File: tb/dma_tx_sched_bench.sv
module dma_tx_sched_bench;
  localparam int NL = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_we = 1'b0;
  logic [1:0] host_addr = 2'd0;
  logic [15:0] host_wdata = 16'd0;
  logic [15:0] host_rdata;
  logic irq, mem_req;
  logic [17:0] mem_addr;
  logic mem_rvalid = 1'b0;
  logic [7:0] mem_rdata = 8'd0;
  logic mem_err = 1'b0;
  logic [NL-1:0] out_valid;
  logic [NL*8-1:0] out_data;
  logic [NL-1:0] out_ready = '1;

  always #5 clk = ~clk;

  dma_tx_sched u_dma_tx_sched (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .irq(irq),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .mem_err(mem_err), .out_valid(out_valid),
    .out_data(out_data), .out_ready(out_ready)
  );

  int n_chk = 0, n_fail = 0, req_seen = 0;
  bit done = 0;
  logic [11:0] exp_q [$];
  int rem [NL];
  logic [17:0] cur [NL];
  int rr_last = NL - 1;

  function automatic logic [7:0] mem_byte(input logic [17:0] a);
    return (a[7:0] ^ a[15:8]) + 8'(a[17:16]) * 8'd37;
  endfunction

  // memory model: two-cycle latency, addresses with bit 17 set do not exist
  logic s1 = 1'b0;
  logic [17:0] a1 = '0;
  always @(posedge clk) begin
    s1 <= mem_req;
    if (mem_req) begin
      a1 <= mem_addr;
      req_seen <= req_seen + 1;
    end
    mem_rvalid <= s1;
    mem_rdata  <= mem_byte(a1);
    mem_err    <= s1 && a1[17];
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      for (int i = 0; i < NL; i++) begin
        if (out_valid[i] && out_ready[i]) begin
          if (exp_q.size() == 0) chk("R4 unexpected byte", {20'd0, 4'(i), out_data[i*8 +: 8]}, 32'hFFFFFFFF);
          else chk("R4/R8 byte order", {20'd0, 4'(i), out_data[i*8 +: 8]}, {20'd0, exp_q.pop_front()});
        end
      end
    end
  end

  task automatic hw(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic hr(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    host_addr = a;
    #1 d = host_rdata;
  endtask

  function automatic logic [15:0] cw(input int sel, input int ext, input bit tie, input bit keep_ti, input bit clr_nxm);
    return 16'((keep_ti << 15) | (tie << 13) | (clr_nxm << 8) | (ext << 4) | sel);
  endfunction

  task automatic program_line(input int l, input int ext, input logic [15:0] a, input int n);
    hw(2'd0, cw(l, ext, 0, 0, 0));
    hw(2'd1, a);
    hw(2'd2, 16'd0 - 16'(n));
  endtask

  // expected delivery order by round-robin prediction
  task automatic plan_rr();
    int tot = 0;
    foreach (rem[k]) tot += rem[k];
    while (tot > 0) begin
      for (int s = 1; s <= NL; s++) begin
        int l;
        l = (rr_last + s) % NL;
        if (rem[l] > 0) begin
          exp_q.push_back({4'(l), mem_byte(cur[l])});
          cur[l] = cur[l] + 1'b1;
          rem[l]--;
          rr_last = l;
          tot--;
          break;
        end
      end
    end
  endtask

  task automatic wait_mask_clear();
    logic [15:0] v;
    for (int t = 0; t < 2000; t++) begin
      hr(2'd3, v);
      if (v == 16'd0) break;
    end
    repeat (6) @(negedge clk);
  endtask

  initial begin
    logic [15:0] v;
    int rq;
    foreach (rem[k]) begin rem[k] = 0; cur[k] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    hr(2'd0, v); chk("R1 ctrl", v, 0);
    hr(2'd3, v); chk("R1 mask", v, 0);
    chk("R1 outputs", {irq, mem_req, out_valid}, 0);

    // R2 line select, R4 zero mask write ignored
    program_line(6, 0, 16'h1234, 5);
    program_line(3, 0, 16'hFFFE, 4);
    hw(2'd0, cw(6, 0, 0, 0, 0));
    hr(2'd1, v); chk("R2 addr line6", v, 16'h1234);
    hr(2'd2, v); chk("R2 cnt line6", v, 16'hFFFB);
    hw(2'd3, 16'h0000);
    repeat (20) @(negedge clk);
    hr(2'd3, v); chk("R4 zero mask write", v, 0);
    chk("R4 no bytes after zero write", req_seen, 0);
    hr(2'd1, v); chk("R4 addr untouched", v, 16'h1234);

    // R3/R5/R6 single line across the 64 KiB boundary
    rem[3] = 4; cur[3] = 18'h0FFFE; plan_rr();
    hw(2'd3, 16'h0008);
    wait_mask_clear();
    chk("R4 all bytes delivered", exp_q.size(), 0);
    hr(2'd0, v); chk("R6 flag set after retire", v, 16'h8006);
    chk("R6 irq off without enable", irq, 0);
    hw(2'd0, cw(3, 0, 1, 1, 0));
    chk("R6 irq with enable", irq, 1);
    hr(2'd0, v); chk("R3 ctrl ext reads carry", v, 16'hA013);
    hr(2'd1, v); chk("R5 end address", v, 16'h0002);
    hr(2'd2, v); chk("R5 end count", v, 16'h0000);
    hw(2'd0, cw(3, 0, 0, 0, 0));
    hr(2'd0, v); chk("R6 flag cleared", v, 16'h0013);
    chk("R6 irq cleared", irq, 0);

    // R8 round-robin over three lines started together
    program_line(1, 0, 16'h0100, 2);
    program_line(4, 0, 16'h2000, 3);
    program_line(14, 1, 16'h0040, 1);
    rem[1] = 2; cur[1] = 18'h00100;
    rem[4] = 3; cur[4] = 18'h02000;
    rem[14] = 1; cur[14] = 18'h10040;
    plan_rr();
    hw(2'd3, 16'h4012);
    wait_mask_clear();
    chk("R8 rr all delivered", exp_q.size(), 0);

    // R8 backpressure, R7 early stop
    out_ready[5] = 1'b0;
    program_line(5, 0, 16'h0300, 100);
    hw(2'd3, 16'h0020);
    repeat (20) @(negedge clk);
    chk("R8 held byte waits", out_valid[5], 1);
    hr(2'd2, v); chk("R8 no fetch while held", v, 16'hFF9D);
    hr(2'd1, v); chk("R8 addr while held", v, 16'h0301);
    hw(2'd2, 16'hFFFF);
    rem[5] = 2; cur[5] = 18'h00300; plan_rr();
    out_ready[5] = 1'b1;
    wait_mask_clear();
    hr(2'd1, v); chk("R7 stop address", v, 16'h0302);
    hr(2'd2, v); chk("R7 stop count", v, 16'h0000);
    chk("R7 bytes after stop", exp_q.size(), 0);

    // R9 nonexistent memory
    hw(2'd0, cw(5, 0, 0, 0, 0));
    program_line(7, 2, 16'h0000, 3);
    hw(2'd3, 16'h0080);
    wait_mask_clear();
    rr_last = 7;
    hr(2'd0, v); chk("R9 nxm and flag", v, 16'h8427);
    hr(2'd1, v); chk("R9 addr unchanged", v, 16'h0000);
    hr(2'd2, v); chk("R9 cnt unchanged", v, 16'hFFFD);
    hw(2'd0, cw(7, 0, 0, 0, 1));
    hr(2'd0, v); chk("R9 nxm cleared", v, 16'h0027);

    // R10 zero-length start
    program_line(9, 0, 16'h0500, 0);
    rq = req_seen;
    hw(2'd3, 16'h0200);
    repeat (5) @(negedge clk);
    hr(2'd3, v); chk("R10 retired", v, 0);
    hr(2'd0, v); chk("R10 flag", v, 16'h8009);
    hr(2'd1, v); chk("R10 addr", v, 16'h0500);
    chk("R10 no read", req_seen - rq, 0);

    chk("R4 scoreboard empty", exp_q.size(), 0);
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule